// File: doc/BRIEF.md
# Saturating up/down counter field

This block is the hardware side of a counter kept inside a register field. Two single-cycle strobes, one for counting up and one for counting down, move the count by a per-direction step. Each step is chosen at build time. It can be a fixed constant, which is 1 when nothing else is chosen. It can be a value taken from an input port in the same cycle as the strobe. A direction can also be removed altogether. Building the block with both directions removed stops elaboration with an error.

Each direction may carry an optional limit. When the two strobes fall in the same cycle, their steps are merged into one net movement, and every enabled limit is judged against that net result. A movement that would leave the permitted range is not clamped. It is dropped in full, and the count keeps its old value. A direction without a limit wraps modulo 2^WIDTH. Combinational logic forms the candidate value and a load flag, and the field register takes the candidate only when the flag is set. Software decode, threshold and overflow flags are not part of this block.

Top module: `sat_updown_field`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count loads `RST_VAL` at that edge.
- R2: A direction with neither a step width nor a step value chosen (`INC_STEP`/`DEC_STEP` left at 1, `*_STEP_W` = 0) moves the count by exactly 1 per strobe.
- R3: A direction with a constant step `INC_STEP`/`DEC_STEP` = k > 0 and `*_STEP_W` = 0 moves the count by k per strobe.
- R4: A direction with `*_STEP_W` > 0 moves the count by the unsigned value on its step port, sampled in the same cycle as the strobe.
- R5: With `INC_SAT` = 1, a movement whose result would be greater than `INC_LIMIT` is skipped and the count holds. `INC_LIMIT` defaults to 2^WIDTH−1.
- R6: With `DEC_SAT` = 1, a movement whose result would be less than `DEC_LIMIT` is skipped and the count holds. `DEC_LIMIT` defaults to 0.
- R7: When both directions are present and either strobe is high, the result is count + up-step − down-step. Both enabled limits are checked on that one net value, and the movement is taken only if every check passes.
- R8: A direction whose strobe is low adds nothing. With both strobes low, the count holds.
- R9: A direction without a limit wraps modulo 2^WIDTH, both upward and downward.
- R10: A direction whose step value is 0 (with `*_STEP_W` = 0) is absent. Its strobe and step port have no effect on the count.
- R11: The count changes only in a cycle where the internal load flag is set, and it then takes the candidate value formed in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_i | input | 1 | Count-up strobe |
| dec_i | input | 1 | Count-down strobe |
| inc_step_i | input | INC_STEP_W (1 when 0) | Up step, used only when INC_STEP_W > 0 |
| dec_step_i | input | DEC_STEP_W (1 when 0) | Down step, used only when DEC_STEP_W > 0 |
| count_o | output | WIDTH | Current field value |

## Verification
The up and down strobes can be high in the same cycle. They then produce one net movement, and that movement can run into either limit even when it is smaller than each step taken alone. The bench steps an LFSR that sets both strobes and both dynamic step values independently every cycle. Both-high cycles are therefore frequent, with every step size and with counts sitting near each limit. Four 4-bit instances are checked: dynamic steps with both limits, default and constant steps with wrap-around, up-only, and down-only. Each cycle's count is compared against an arithmetic model of net movement, limit and wrap, with periodic resets to refill counts that have drained to a limit.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_CONST = 2'd1,
    STEP_PORT  = 2'd2
  } step_src_e;

  // A port width takes precedence; a fixed value of 0 removes the direction.
  function automatic step_src_e pick_src(int fixed_val, int port_w);
    if (port_w > 0) return STEP_PORT;
    if (fixed_val == 0) return STEP_NONE;
    return STEP_CONST;
  endfunction

  // Bits needed to hold a positive constant: floor(log2(v)) + 1.
  function automatic int const_bits(int v);
    if (v <= 1) return 1;
    return $clog2(v + 1);
  endfunction

  function automatic int port_bits(int w);
    return (w > 0) ? w : 1;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sat_cnt_step_src.sv
module sat_cnt_step_src
  import sat_cnt_pkg::*;
#(
  parameter step_src_e SRC    = STEP_CONST,
  parameter int        FIXED  = 1,
  parameter int        PORT_W = 1,
  parameter int        EXT_W  = 8
) (
  input  logic              strobe_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [EXT_W-1:0]  step_o,
  output logic              active_o
);

  generate
    if (SRC == STEP_PORT) begin : g_port
      assign active_o = strobe_i;
      assign step_o   = strobe_i ? EXT_W'(port_i) : '0;
    end else if (SRC == STEP_CONST) begin : g_const
      localparam int CW = const_bits(FIXED);
      logic [CW-1:0]     fixed_step;
      logic [PORT_W-1:0] unused_port;
      assign fixed_step  = CW'(FIXED);
      assign unused_port = port_i;
      assign active_o    = strobe_i;
      assign step_o      = strobe_i ? EXT_W'(fixed_step) : '0;
    end else begin : g_none
      logic [PORT_W-1:0] unused_port;
      logic              unused_strobe;
      assign unused_port   = port_i;
      assign unused_strobe = strobe_i;
      assign active_o      = 1'b0;
      assign step_o        = '0;
    end
  endgenerate

endmodule

// File: rtl/sat_cnt_next.sv
module sat_cnt_next #(
  parameter int WIDTH     = 8,
  parameter int EXT_W     = 10,
  parameter bit INC_SAT   = 1'b0,
  parameter int INC_LIMIT = 255,
  parameter bit DEC_SAT   = 1'b0,
  parameter int DEC_LIMIT = 0
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [EXT_W-1:0] up_step_i,
  input  logic [EXT_W-1:0] dn_step_i,
  input  logic             up_act_i,
  input  logic             dn_act_i,
  output logic [WIDTH-1:0] next_o,
  output logic             update_o,
  output logic             over_ceiling_o,
  output logic             under_floor_o
);

  localparam logic signed [EXT_W-1:0] CEIL  = EXT_W'(INC_LIMIT);
  localparam logic signed [EXT_W-1:0] FLOOR = EXT_W'(DEC_LIMIT);

  // Net movement in a signed domain two bits wider than any operand.
  function automatic logic signed [EXT_W-1:0] net_value(
    input logic [WIDTH-1:0] q,
    input logic [EXT_W-1:0] up,
    input logic [EXT_W-1:0] dn
  );
    return $signed(EXT_W'(q)) + $signed(up) - $signed(dn);
  endfunction

  logic signed [EXT_W-1:0] net;
  assign net = net_value(q_i, up_step_i, dn_step_i);

  generate
    if (INC_SAT) begin : g_ceil
      assign over_ceiling_o = (net > CEIL);
    end else begin : g_no_ceil
      assign over_ceiling_o = 1'b0;
    end
    if (DEC_SAT) begin : g_floor
      assign under_floor_o = (net < FLOOR);
    end else begin : g_no_floor
      assign under_floor_o = 1'b0;
    end
  endgenerate

  assign update_o = (up_act_i || dn_act_i) && !over_ceiling_o && !under_floor_o;
  assign next_o   = net[WIDTH-1:0];

endmodule

// File: rtl/sat_cnt_reg.sv
module sat_cnt_reg #(
  parameter int WIDTH   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= WIDTH'(RST_VAL);
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/sat_updown_field.sv
module sat_updown_field
  import sat_cnt_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int INC_STEP   = 1,
  parameter int INC_STEP_W = 0,
  parameter int DEC_STEP   = 1,
  parameter int DEC_STEP_W = 0,
  parameter bit INC_SAT    = 1'b0,
  parameter int INC_LIMIT  = (1 << WIDTH) - 1,
  parameter bit DEC_SAT    = 1'b0,
  parameter int DEC_LIMIT  = 0,
  parameter int RST_VAL    = 0
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        inc_i,
  input  logic                                        dec_i,
  input  logic [((INC_STEP_W > 0) ? INC_STEP_W : 1)-1:0] inc_step_i,
  input  logic [((DEC_STEP_W > 0) ? DEC_STEP_W : 1)-1:0] dec_step_i,
  output logic [WIDTH-1:0]                            count_o
);

  localparam step_src_e INC_SRC = pick_src(INC_STEP, INC_STEP_W);
  localparam step_src_e DEC_SRC = pick_src(DEC_STEP, DEC_STEP_W);
  localparam int INC_PW = port_bits(INC_STEP_W);
  localparam int DEC_PW = port_bits(DEC_STEP_W);
  localparam int OPND_W = max_of(max_of(WIDTH, max_of(INC_PW, DEC_PW)),
                                 max_of(const_bits(INC_STEP), const_bits(DEC_STEP)));
  localparam int EXT_W  = OPND_W + 2;

  generate
    if (INC_SRC == STEP_NONE && DEC_SRC == STEP_NONE) begin : g_bad_cfg
      $error("sat_updown_field: both count directions removed");
    end
  endgenerate

  logic [EXT_W-1:0] up_step_w;
  logic [EXT_W-1:0] dn_step_w;
  logic             up_act_w;
  logic             dn_act_w;
  logic [WIDTH-1:0] next_w;
  logic             upd_w;
  logic             over_ceiling_w;
  logic             under_floor_w;

  sat_cnt_step_src #(
    .SRC(INC_SRC), .FIXED(INC_STEP), .PORT_W(INC_PW), .EXT_W(EXT_W)
  ) u_up_src (
    .strobe_i(inc_i), .port_i(inc_step_i), .step_o(up_step_w), .active_o(up_act_w)
  );

  sat_cnt_step_src #(
    .SRC(DEC_SRC), .FIXED(DEC_STEP), .PORT_W(DEC_PW), .EXT_W(EXT_W)
  ) u_dn_src (
    .strobe_i(dec_i), .port_i(dec_step_i), .step_o(dn_step_w), .active_o(dn_act_w)
  );

  sat_cnt_next #(
    .WIDTH(WIDTH), .EXT_W(EXT_W),
    .INC_SAT(INC_SAT), .INC_LIMIT(INC_LIMIT),
    .DEC_SAT(DEC_SAT), .DEC_LIMIT(DEC_LIMIT)
  ) u_next (
    .q_i(count_o), .up_step_i(up_step_w), .dn_step_i(dn_step_w),
    .up_act_i(up_act_w), .dn_act_i(dn_act_w),
    .next_o(next_w), .update_o(upd_w),
    .over_ceiling_o(over_ceiling_w), .under_floor_o(under_floor_w)
  );

  sat_cnt_reg #(
    .WIDTH(WIDTH), .RST_VAL(RST_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .load_i(upd_w), .d_i(next_w), .q_o(count_o)
  );

endmodule

// File: rtl/sat_updown_field_chk.sv
module sat_updown_field_chk #(
  parameter int WIDTH      = 8,
  parameter int INC_STEP   = 1,
  parameter int INC_STEP_W = 0,
  parameter int DEC_STEP   = 1,
  parameter int DEC_STEP_W = 0,
  parameter bit INC_SAT    = 1'b0,
  parameter int INC_LIMIT  = 255,
  parameter bit DEC_SAT    = 1'b0,
  parameter int DEC_LIMIT  = 0,
  parameter int RST_VAL    = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc_i,
  input logic             dec_i,
  input logic [WIDTH-1:0] count_o,
  input logic             upd,
  input logic [WIDTH-1:0] next_q
);

  logic rst_q     = 1'b1;
  logic rst_valid = 1'b0;

  always @(posedge clk) begin
    if (rst_valid && !rst_q) begin
      assert_reset_value_R1: assert (count_o == WIDTH'(RST_VAL))
        else $error("R1: count %0d after reset, expected %0d", count_o, RST_VAL);
    end
    rst_q     <= rst_n;
    rst_valid <= 1'b1;
  end

  assert_hold_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> count_o == $past(count_o));

  assert_load_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> count_o == $past(next_q));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !dec_i) |=> $stable(count_o));

  assert_ceiling_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (INC_SAT && (count_o <= INC_LIMIT)) |=> (count_o <= INC_LIMIT));

  assert_floor_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (DEC_SAT && (count_o >= DEC_LIMIT)) |=> (count_o >= DEC_LIMIT));

  generate
    if (INC_STEP == 0 && INC_STEP_W == 0) begin : g_no_up
      assert_up_removed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> $stable(count_o));
    end
    if (DEC_STEP == 0 && DEC_STEP_W == 0) begin : g_no_dn
      assert_dn_removed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |=> $stable(count_o));
    end
  endgenerate

endmodule

bind sat_updown_field sat_updown_field_chk #(
  .WIDTH(WIDTH), .INC_STEP(INC_STEP), .INC_STEP_W(INC_STEP_W),
  .DEC_STEP(DEC_STEP), .DEC_STEP_W(DEC_STEP_W),
  .INC_SAT(INC_SAT), .INC_LIMIT(INC_LIMIT),
  .DEC_SAT(DEC_SAT), .DEC_LIMIT(DEC_LIMIT), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i),
  .count_o(count_o), .upd(upd_w), .next_q(next_w)
);

// File: tb/sat_updown_field_test.sv
module sat_updown_field_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_s = 1'b0;
  logic       dec_s = 1'b0;
  logic [2:0] istep = '0;
  logic [2:0] dstep = '0;
  logic [3:0] cnt_a, cnt_b, cnt_c, cnt_d;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // A: dynamic 3-bit steps, ceiling 13, floor 2
  sat_updown_field #(.WIDTH(4), .INC_STEP_W(3), .DEC_STEP_W(3),
    .INC_SAT(1'b1), .INC_LIMIT(13), .DEC_SAT(1'b1), .DEC_LIMIT(2), .RST_VAL(5))
  uut (.clk(clk), .rst_n(rst_n), .inc_i(inc_s), .dec_i(dec_s),
       .inc_step_i(istep), .dec_step_i(dstep), .count_o(cnt_a));

  // B: default up step, constant down step 3, no limits (wraps)
  sat_updown_field #(.WIDTH(4), .DEC_STEP(3), .RST_VAL(1))
  u_b (.clk(clk), .rst_n(rst_n), .inc_i(inc_s), .dec_i(dec_s),
       .inc_step_i(istep[0]), .dec_step_i(dstep[0]), .count_o(cnt_b));

  // C: up only, constant 5, default ceiling 15
  sat_updown_field #(.WIDTH(4), .INC_STEP(5), .DEC_STEP(0), .INC_SAT(1'b1), .RST_VAL(0))
  u_c (.clk(clk), .rst_n(rst_n), .inc_i(inc_s), .dec_i(dec_s),
       .inc_step_i(istep[0]), .dec_step_i(dstep[0]), .count_o(cnt_c));

  // D: down only, dynamic 2-bit step, default floor 0
  sat_updown_field #(.WIDTH(4), .INC_STEP(0), .DEC_STEP_W(2), .DEC_SAT(1'b1), .RST_VAL(9))
  u_d (.clk(clk), .rst_n(rst_n), .inc_i(inc_s), .dec_i(dec_s),
       .inc_step_i(istep[0]), .dec_step_i(dstep[1:0]), .count_o(cnt_d));

  function automatic int model(int q, bit up, bit dn, int us, int ds,
                               bit up_on, bit dn_on, bit csat, int ceil_v,
                               bit fsat, int floor_v);
    int net;
    bit moving;
    moving = (up_on && up) || (dn_on && dn);
    if (!moving) return q;
    net = q;
    if (up_on && up) net = net + us;
    if (dn_on && dn) net = net - ds;
    if (csat && net > ceil_v) return q;
    if (fsat && net < floor_v) return q;
    return ((net % 16) + 16) % 16;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    int ma, mb, mc, md, ea, eb, ec, ed;
    lfsr = 16'hACE1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset A", cnt_a, 5);
    chk("R1 reset B", cnt_b, 1);
    chk("R1 reset C", cnt_c, 0);
    chk("R1 reset D", cnt_d, 9);
    ma = 5; mb = 1; mc = 0; md = 9;
    rst_n = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < 8; k++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inc_s = lfsr[0];
      dec_s = lfsr[3];
      istep = lfsr[6:4];
      dstep = lfsr[10:8];
      rst_n = ((n % 500) != 499);
      if (!rst_n) begin
        ea = 5; eb = 1; ec = 0; ed = 9;
      end else begin
        ea = model(ma, inc_s, dec_s, istep, dstep, 1, 1, 1, 13, 1, 2);
        eb = model(mb, inc_s, dec_s, 1, 3, 1, 1, 0, 0, 0, 0);
        ec = model(mc, inc_s, dec_s, 5, 0, 1, 0, 1, 15, 0, 0);
        ed = model(md, inc_s, dec_s, 0, int'(dstep[1:0]), 0, 1, 0, 0, 1, 0);
      end
      @(negedge clk);
      chk(rst_n ? "R4/R5/R6/R7/R8/R11 A" : "R1 A", cnt_a, ea);
      chk(rst_n ? "R2/R3/R7/R9 B" : "R1 B", cnt_b, eb);
      chk(rst_n ? "R3/R5/R10 C" : "R1 C", cnt_c, ec);
      chk(rst_n ? "R4/R6/R10 D" : "R1 D", cnt_d, ed);
      ma = ea; mb = eb; mc = ec; md = ed;
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule